// File: doc/BRIEF.md
# Single-Precision Reciprocal Square-Root Unit

This unit computes 1/sqrt(x) for a binary32 operand. One start pulse carries the operand and a 3-bit rounding mode. A fixed number of cycles later the unit raises a one-cycle done pulse. With it come the 32-bit result and two exception flags: invalid operation and divide-by-zero. The datapath for finite positive operands is a bit-serial digit recurrence. It fixes one result bit per cycle by comparing the trial root squared, times the operand significand, against a constant. Only shifts and adds are needed for this. The final remainder tells the rounder whether the value was exact, so the result is rounded once from the exact value. The unit uses no table and no iterative refinement, so its latency does not depend on the data.

Special operands (NaN, infinities, zeros, negative values) are sorted out when the operand is accepted. They still come out at the same fixed latency as every other result. Subnormal inputs count as zeros of the same sign. The result exponent of any normal input stays in the normal range, so overflow and underflow cannot occur.

Top module: `rsqrt_unit`

## Requirements
- R1: An input with exponent field 0xFF and a nonzero fraction returns 0x7FC00000. The invalid flag is raised only when fraction bit 22 is 0 (signaling NaN).
- R2: A negative input that is not a zero (a negative normal, or 0xFF800000) returns 0x7FC00000 and raises the invalid flag.
- R3: An input with exponent field 0, of either sign and with any fraction, returns an infinity of the same sign as the input. It raises the divide-by-zero flag. The sign check never turns -0 into an invalid case.
- R4: Input 0x7F800000 returns 0x00000000 with both flags low.
- R5: A positive normal input returns 1/sqrt(x), correctly rounded once under the rounding mode, with both flags low. The modes are 000 nearest-even, 001 toward zero, 010 toward minus infinity, 011 toward plus infinity, and 100 nearest with ties away from zero. For example, 2.0 gives 0x3F3504F3 under 000 and 0x3F3504F4 under 011.
- R6: Exact powers of four give exact results in every mode: 1.0 gives 0x3F800000, 4.0 gives 0x3F000000, 0.25 gives 0x40000000 and 16.0 gives 0x3E800000.
- R7: A rounding mode of 101, 110 or 111 returns 0x7FC00000 and raises the invalid flag, whatever the operand.
- R8: When a start is accepted, done rises exactly 28 cycles later, counted from the clock edge that sampled start. This holds for every operand class. Done lasts one cycle.
- R9: A start raised while an operation is in flight is ignored. It produces no extra done and does not disturb the result of the operation in flight.
- R10: Both flags are low whenever done is low. The result stays stable between done pulses.
- R11: During reset, done, both flags and the result are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| start | input | 1 | Begin an operation using operand and rmode |
| operand | input | 32 | binary32 input x |
| rmode | input | 3 | Rounding mode code |
| done | output | 1 | One-cycle pulse marking a valid result |
| result | output | 32 | binary32 value of 1/sqrt(x) |
| flag_inv | output | 1 | Invalid-operation flag, valid with done |
| flag_dz | output | 1 | Divide-by-zero flag, valid with done |

## Verification
A wrong bit decision in the recurrence is never corrected later. It shows up in the very next result as a significand that differs from the exact reference in an upper bit, or as a rounding error in the last place when only the remainder test is wrong. A corrupted step count or control state shows at the ports as a done pulse that arrives early, late or twice, so it is caught at the first operation after the fault. A captured operand class that is wrong shows at the ports as a wrong special value or wrong flags on that same done.

// File: rtl/rsqrt_pkg.sv
package rsqrt_pkg;

  typedef enum logic [2:0] {
    RM_RNE = 3'b000,
    RM_RTZ = 3'b001,
    RM_RDN = 3'b010,
    RM_RUP = 3'b011,
    RM_RMM = 3'b100
  } rm_e;

  typedef enum logic [2:0] {
    CL_NORMAL = 3'd0,
    CL_QNAN   = 3'd1,
    CL_SNAN   = 3'd2,
    CL_NEG    = 3'd3,
    CL_ZERO   = 3'd4,
    CL_PINF   = 3'd5,
    CL_BADRM  = 3'd6
  } cls_e;

endpackage

// File: rtl/rsqrt_classify.sv
module rsqrt_classify
  import rsqrt_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W,
  localparam int unsigned A_W   = FRAC_W + 2
) (
  input  logic [W-1:0]     x,
  input  logic [2:0]       rm,
  output cls_e             cls,
  output logic [A_W-1:0]   a_sig,
  output logic [EXP_W-1:0] rexp
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  logic             sgn;
  logic [EXP_W-1:0] ef;
  logic [FRAC_W-1:0] fr;
  logic             ef_zero, ef_ones, fr_zero, odd_exp;
  int               ep, hf, re;

  always_comb begin
    sgn     = x[W-1];
    ef      = x[W-2:FRAC_W];
    fr      = x[FRAC_W-1:0];
    ef_zero = (ef == '0);
    ef_ones = (ef == '1);
    fr_zero = (fr == '0);

    if (rm > 3'(RM_RMM))           cls = CL_BADRM;
    else if (ef_ones && !fr_zero)  cls = fr[FRAC_W-1] ? CL_QNAN : CL_SNAN;
    else if (ef_zero)              cls = CL_ZERO;
    else if (ef_ones)              cls = sgn ? CL_NEG : CL_PINF;
    else if (sgn)                  cls = CL_NEG;
    else                           cls = CL_NORMAL;

    // bias is odd, so an even biased field means an odd unbiased exponent
    odd_exp = ~ef[0];
    a_sig   = odd_exp ? {1'b1, fr, 1'b0} : {1'b0, 1'b1, fr};

    ep   = int'(ef) - BIAS - int'(odd_exp);
    hf   = ep >>> 1;
    re   = BIAS - 1 - hf;
    rexp = EXP_W'(re);
  end

endmodule

// File: rtl/rsqrt_recur.sv
module rsqrt_recur #(
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned A_W   = FRAC_W + 2,
  localparam int unsigned Q_W   = FRAC_W + 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step_en,
  input  logic [A_W-1:0] a_in,
  output logic [Q_W-1:0] q_o,
  output logic           inexact_o,
  output logic           last_o
);
  localparam int unsigned P     = Q_W - 1;
  localparam int unsigned ACC_W = 2 * Q_W + A_W + 2;
  localparam int unsigned IDX_W = $clog2(Q_W);
  localparam int unsigned C_SH  = 2 * P + FRAC_W;
  localparam logic [ACC_W-1:0] C_VAL   = {{(ACC_W-1){1'b0}}, 1'b1} << C_SH;
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(Q_W - 1);

  logic [A_W-1:0]   a_q, a_d;
  logic [ACC_W-1:0] t_q, t_d, u_q, u_d, a_ext, cand;
  logic [Q_W-1:0]   q_q, q_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W:0]   sh_u, sh_a;
  logic             take;

  always_comb begin
    a_ext = {{(ACC_W-A_W){1'b0}}, a_q};
    sh_u  = {1'b0, idx_q} + {{IDX_W{1'b0}}, 1'b1};
    sh_a  = {idx_q, 1'b0};
    // (q + 2^i)^2 * A = T + (A*q) * 2^(i+1) + A * 2^(2i)
    cand  = t_q + (u_q << sh_u) + (a_ext << sh_a);
    take  = (cand <= C_VAL);

    a_d   = a_q;
    t_d   = t_q;
    u_d   = u_q;
    q_d   = q_q;
    idx_d = idx_q;
    if (load) begin
      a_d   = a_in;
      t_d   = '0;
      u_d   = '0;
      q_d   = '0;
      idx_d = IDX_TOP;
    end else if (step_en) begin
      if (take) begin
        t_d = cand;
        u_d = u_q + (a_ext << idx_q);
        q_d = q_q | ({{(Q_W-1){1'b0}}, 1'b1} << idx_q);
      end
      if (idx_q != '0) idx_d = idx_q - {{(IDX_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      t_q   <= '0;
      u_q   <= '0;
      q_q   <= '0;
      idx_q <= '0;
    end else begin
      a_q   <= a_d;
      t_q   <= t_d;
      u_q   <= u_d;
      q_q   <= q_d;
      idx_q <= idx_d;
    end
  end

  assign q_o       = q_q;
  assign inexact_o = (t_q != C_VAL);
  assign last_o    = (idx_q == '0);

endmodule

// File: rtl/rsqrt_round.sv
module rsqrt_round
  import rsqrt_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W,
  localparam int unsigned SIG_W = FRAC_W + 1,
  localparam int unsigned Q_W   = FRAC_W + 4
) (
  input  cls_e             cls,
  input  logic             sign,
  input  logic [2:0]       rm,
  input  logic [EXP_W-1:0] rexp,
  input  logic [Q_W-1:0]   q,
  input  logic             inexact,
  output logic [W-1:0]     res,
  output logic             inv,
  output logic             dz
);
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [SIG_W-1:0] sig;
  logic [SIG_W:0]   sum;
  logic             rbit, sticky, up, carry;
  logic [EXP_W-1:0] eout;
  logic [FRAC_W-1:0] fout;

  always_comb begin
    sig    = q[Q_W-2:2];
    rbit   = q[1];
    sticky = q[0] | inexact;
    case (rm)
      3'(RM_RNE): up = rbit & (sticky | sig[0]);
      3'(RM_RUP): up = rbit | sticky;
      3'(RM_RMM): up = rbit;
      default:    up = 1'b0;
    endcase
    sum   = {1'b0, sig} + {{SIG_W{1'b0}}, up};
    carry = q[Q_W-1] | sum[SIG_W];
    eout  = rexp + {{(EXP_W-1){1'b0}}, carry};
    fout  = carry ? '0 : sum[FRAC_W-1:0];

    res = QNAN;
    inv = 1'b0;
    dz  = 1'b0;
    case (cls)
      CL_NORMAL: res = {1'b0, eout, fout};
      CL_QNAN:   res = QNAN;
      CL_ZERO: begin
        res = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        dz  = 1'b1;
      end
      CL_PINF:   res = '0;
      default:   inv = 1'b1;
    endcase
  end

endmodule

// File: rtl/rsqrt_unit.sv
module rsqrt_unit
  import rsqrt_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] operand,
  input  logic [2:0]   rmode,
  output logic         done,
  output logic [W-1:0] result,
  output logic         flag_inv,
  output logic         flag_dz
);
  localparam int unsigned A_W = FRAC_W + 2;
  localparam int unsigned Q_W = FRAC_W + 4;
  localparam int unsigned LAT = Q_W + 1;

  logic rst_meta_q, rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  cls_e             cls_c, cls_q, cls_d;
  logic [A_W-1:0]   a_c;
  logic [EXP_W-1:0] rexp_c, rexp_q, rexp_d;
  logic             sgn_q, sgn_d;
  logic [2:0]       rm_q, rm_d;
  logic             busy_q, busy_d, fin_q, fin_d, accept;
  logic [Q_W-1:0]   q_w;
  logic             inexact_w, last_w;
  logic [W-1:0]     rnd_res, res_q, res_d;
  logic             rnd_inv, rnd_dz;
  logic             done_q, done_d, inv_q, inv_d, dz_q, dz_d;

  rsqrt_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
    .x     (operand),
    .rm    (rmode),
    .cls   (cls_c),
    .a_sig (a_c),
    .rexp  (rexp_c)
  );

  rsqrt_recur #(.FRAC_W(FRAC_W)) u_rec (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .load      (accept),
    .step_en   (busy_q),
    .a_in      (a_c),
    .q_o       (q_w),
    .inexact_o (inexact_w),
    .last_o    (last_w)
  );

  rsqrt_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_rnd (
    .cls     (cls_q),
    .sign    (sgn_q),
    .rm      (rm_q),
    .rexp    (rexp_q),
    .q       (q_w),
    .inexact (inexact_w),
    .res     (rnd_res),
    .inv     (rnd_inv),
    .dz      (rnd_dz)
  );

  always_comb begin
    accept = start & ~busy_q & ~fin_q;

    busy_d = busy_q;
    if (accept)               busy_d = 1'b1;
    else if (busy_q && last_w) busy_d = 1'b0;
    fin_d = busy_q & last_w;

    cls_d  = cls_q;
    sgn_d  = sgn_q;
    rm_d   = rm_q;
    rexp_d = rexp_q;
    if (accept) begin
      cls_d  = cls_c;
      sgn_d  = operand[W-1];
      rm_d   = rmode;
      rexp_d = rexp_c;
    end

    done_d = fin_q;
    res_d  = fin_q ? rnd_res : res_q;
    inv_d  = fin_q & rnd_inv;
    dz_d   = fin_q & rnd_dz;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      cls_q  <= CL_NORMAL;
      sgn_q  <= 1'b0;
      rm_q   <= '0;
      rexp_q <= '0;
      done_q <= 1'b0;
      res_q  <= '0;
      inv_q  <= 1'b0;
      dz_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      fin_q  <= fin_d;
      cls_q  <= cls_d;
      sgn_q  <= sgn_d;
      rm_q   <= rm_d;
      rexp_q <= rexp_d;
      done_q <= done_d;
      res_q  <= res_d;
      inv_q  <= inv_d;
      dz_q   <= dz_d;
    end
  end

  assign done     = done_q;
  assign result   = res_q;
  assign flag_inv = inv_q;
  assign flag_dz  = dz_q;

endmodule

// File: rtl/rsqrt_unit_chk.sv
module rsqrt_unit_chk #(
  parameter int unsigned LAT   = 28,
  parameter int unsigned EXP_W = 8,
  parameter int unsigned W     = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         fin,
  input logic         done,
  input logic [W-1:0] result,
  input logic         flag_inv,
  input logic         flag_dz
);
  localparam int unsigned CNT_W = $clog2(LAT + 1);
  localparam int unsigned FRAC_W = W - 1 - EXP_W;
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [CNT_W-1:0] LAT_C = CNT_W'(LAT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             accept;

  always_comb begin
    accept = start & ~busy & ~fin;
    cnt_d  = cnt_q;
    if (accept)                          cnt_d = {{(CNT_W-1){1'b0}}, 1'b1};
    else if (cnt_q == LAT_C)             cnt_d = '0;
    else if (cnt_q != '0)                cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                   // R8
  AST_DONE_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LAT_C) |=> done);                                        // R8
  AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(cnt_q) == LAT_C));                                 // R9
  AST_FLAGS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!flag_inv && !flag_dz));                                // R10
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));                                        // R10
  AST_DZ_GIVES_INF: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flag_dz) |-> (result[W-2:0] == INF_MAG));                 // R3
  AST_INV_GIVES_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flag_inv) |-> (result == QNAN));                          // R2
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(flag_inv && flag_dz));                                  // R3
  AST_NONNEG_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !flag_dz && (result != QNAN)) |-> !result[W-1]);          // R5

endmodule

bind rsqrt_unit rsqrt_unit_chk #(.LAT(LAT), .EXP_W(EXP_W), .W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_s),
  .start    (start),
  .busy     (busy_q),
  .fin      (fin_q),
  .done     (done),
  .result   (result),
  .flag_inv (flag_inv),
  .flag_dz  (flag_dz)
);

// File: tb/tb_rsqrt_unit.sv
module tb_rsqrt_unit;
  localparam int LAT = 28;
  localparam logic [31:0] NAN = 32'h7FC00000;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [31:0] operand;
  logic [2:0]  rmode;
  logic        done;
  logic [31:0] result;
  logic        flag_inv;
  logic        flag_dz;

  rsqrt_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .operand(operand), .rmode(rmode),
    .done(done), .result(result), .flag_inv(flag_inv), .flag_dz(flag_dz)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [31:0] res;
    logic        inv;
    logic        dz;
    int          due;
    string       tag;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int fails  = 0;
  logic [31:0] last_res;

  function automatic logic [33:0] ref_calc(input logic [31:0] x, input logic [2:0] rm);
    logic s;
    logic [7:0] ef;
    logic [22:0] fr;
    logic [127:0] a, lo, hi, mid, c, prod;
    logic [24:0] m25;
    logic odd, r, st, up;
    int ep, ex;
    s = x[31]; ef = x[30:23]; fr = x[22:0];
    if (rm > 3'd4) return {2'b10, NAN};
    if (ef == 8'hFF && fr != 0) return {~fr[22], 1'b0, NAN};
    if (ef == 8'h00) return {2'b01, s, 8'hFF, 23'h0};
    if (ef == 8'hFF) return s ? {2'b10, NAN} : {2'b00, 32'h0};
    if (s) return {2'b10, NAN};
    odd = ~ef[0];
    a = odd ? 128'({1'b1, fr, 1'b0}) : 128'({1'b1, fr});
    c = 128'(1) << 75;
    lo = 0; hi = (128'(1) << 27) + 1;
    while (hi - lo > 1) begin
      mid = (lo + hi) >> 1;
      if (mid * mid * a <= c) lo = mid; else hi = mid;
    end
    prod = lo * lo * a;
    ep = int'(ef) - 127 - int'(odd);
    if (lo == (128'(1) << 26)) begin
      ex = 127 - ep / 2;
      return {2'b00, 1'b0, 8'(ex), 23'h0};
    end
    r  = lo[1];
    st = lo[0] | (prod != c);
    case (rm)
      3'd0: up = r & (st | lo[2]);
      3'd3: up = r | st;
      3'd4: up = r;
      default: up = 1'b0;
    endcase
    m25 = {1'b0, lo[25:2]} + 25'(up);
    ex = 126 - ep / 2 + int'(m25[24]);
    return {2'b00, 1'b0, 8'(ex), m25[24] ? 23'h0 : m25[22:0]};
  endfunction

  task automatic push_start(input logic [31:0] x, input logic [2:0] rm,
                            input logic [33:0] ex, input string tag);
    item_t it;
    it.inv = ex[33]; it.dz = ex[32]; it.res = ex[31:0];
    it.due = cyc + LAT + 1; it.tag = tag;
    sb.push_back(it);
    last_res = ex[31:0];
    operand = x; rmode = rm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_hold(input string tag);
    repeat (LAT + 2) @(negedge clk);
    checks++;
    if (result !== last_res || flag_inv !== 1'b0 || flag_dz !== 1'b0) begin
      fails++;
      $display("FAIL %s R10 hold: result=%h inv=%b dz=%b expected %h 0 0",
               tag, result, flag_inv, flag_dz, last_res);
    end
  endtask

  task automatic run(input logic [31:0] x, input logic [2:0] rm, input string tag);
    push_start(x, rm, ref_calc(x, rm), tag);
    wait_hold(tag);
  endtask

  task automatic run_lit(input logic [31:0] x, input logic [2:0] rm,
                         input logic [31:0] exp_res, input string tag);
    push_start(x, rm, {2'b00, exp_res}, tag);
    wait_hold(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R9 stray done: result=%h expected no done", result);
      end else begin
        item_t it;
        it = sb.pop_front();
        if (result !== it.res || flag_inv !== it.inv || flag_dz !== it.dz || cyc != it.due) begin
          fails++;
          $display("FAIL %s: result=%h inv=%b dz=%b cyc=%0d expected %h %b %b cyc=%0d",
                   it.tag, result, flag_inv, flag_dz, cyc, it.res, it.inv, it.dz, it.due);
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; operand = '0; rmode = '0; last_res = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (done !== 1'b0 || flag_inv !== 1'b0 || flag_dz !== 1'b0 || result !== 32'h0) begin
      fails++;
      $display("FAIL R11 reset: done=%b inv=%b dz=%b result=%h expected 0 0 0 0",
               done, flag_inv, flag_dz, result);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // special operands
    run(32'h7FC12345, 3'd0, "R1 qnan");
    run(32'h7F800001, 3'd0, "R1 snan");
    run(32'hFFA00000, 3'd2, "R1 neg snan");
    run(32'hFF800000, 3'd0, "R2 -inf");
    run(32'hBF800000, 3'd1, "R2 -1.0");
    run(32'h80800000, 3'd3, "R2 -min normal");
    run(32'h80000000, 3'd0, "R3 -0");
    run(32'h00000000, 3'd4, "R3 +0");
    run(32'h80000001, 3'd0, "R3 -subnormal");
    run(32'h007FFFFF, 3'd2, "R3 +subnormal");
    run(32'h7F800000, 3'd0, "R4 +inf");
    run(32'h40000000, 3'd5, "R7 rm101");
    run(32'h80000000, 3'd6, "R7 rm110 on -0");
    run(32'h7F800000, 3'd7, "R7 rm111 on +inf");

    // hand values
    run_lit(32'h40000000, 3'd0, 32'h3F3504F3, "R5 2.0 rne");
    run_lit(32'h40000000, 3'd3, 32'h3F3504F4, "R5 2.0 rup");
    run_lit(32'h40000000, 3'd1, 32'h3F3504F3, "R5 2.0 rtz");
    for (int m = 0; m < 5; m++) begin
      run_lit(32'h3F800000, 3'(m), 32'h3F800000, "R6 1.0");
      run_lit(32'h40800000, 3'(m), 32'h3F000000, "R6 4.0");
      run_lit(32'h3E800000, 3'(m), 32'h40000000, "R6 0.25");
      run_lit(32'h41800000, 3'(m), 32'h3E800000, "R6 16.0");
    end

    // extremes of the normal range
    for (int m = 0; m < 5; m++) begin
      run(32'h00800000, 3'(m), "R5 min normal");
      run(32'h7F7FFFFF, 3'(m), "R5 max normal");
      run(32'h3FFFFFFF, 3'(m), "R5 just below 2");
    end

    // random positive normals in every mode
    for (int m = 0; m < 5; m++) begin
      for (int k = 0; k < 30; k++) begin
        logic [31:0] x;
        x = {1'b0, 8'(1 + $urandom_range(253)), 23'($urandom)};
        run(x, 3'(m), "R5 random");
      end
    end

    // start while busy is ignored
    push_start(32'h40400000, 3'd0, ref_calc(32'h40400000, 3'd0), "R9 first");
    repeat (5) @(negedge clk);
    operand = 32'h41200000; rmode = 3'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_hold("R9 overlap");
    repeat (LAT + 4) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R9 pending: queue=%0d expected 0", sb.size());
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule